// File: doc/BRIEF.md
# PLL Divider Search Engine

This block chooses an input divider N and an even feedback divider M for a PLL so that the VCO frequency comes as close as possible to the bit rate needed on each serial lane. A request carries the pixel clock, the number of lanes, a pixel-format code and the reference frequency. All frequencies are integers in kHz.

The block first derives the lane rate target. It then walks N upward through the range that keeps the phase-detector frequency inside its window. For each N it forms a candidate M, screens the candidate and keeps the best one. Every division goes through one iterative shift-subtract divider inside the block, so a search costs roughly 34 cycles per division.

The request side uses a valid/ready handshake. `req_ready_o` is high only while the engine is idle. A request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high. While a search runs, `req_ready_o` stays low and any `req_valid_i` is ignored, so a requester simply holds its request until it is accepted. The result side has no back-pressure: `done_o` pulses for one cycle, and the result outputs hold their value until the next pulse.

Top module: `pll_div_search`

## Requirements
- R1: The target is floor(floor(pclk / lanes) × bpp / 8) × 10, truncating at each step. The bits per pixel come from the format code: 0 → 24, 1 → 24, 2 → 18, 3 → 16.
- R2: A format code from 4 to 7, or a lane count of 0, ends the request with an error. No search is run, and `done_o` rises within two cycles of acceptance.
- R3: A target of 1,500,000 kHz or more ends the request with an error.
- R4: N is tried upward from max(1, ceil(fref / 40,000)) to floor(fref / 5,000). A reported N satisfies N × 40,000 ≥ fref and N × 5,000 ≤ fref.
- R5: For each N, M is floor(target × N / fref), plus 1 when that value is odd. A candidate is dropped when M is below 6 or above 512.
- R6: The VCO frequency is floor(M × fref / N). A candidate is dropped when it is below 80,000 kHz or above 1,500,000 kHz.
- R7: A surviving candidate replaces the kept one only when its absolute distance from the target is strictly smaller. The starting distance is 1,500,000 kHz, so on a tie the lower N wins.
- R8: When no candidate survives, including when the N range is empty, the request ends with an error.
- R9: `done_o` is high for exactly one cycle per accepted request. `err_o`, `div_n_o`, `div_m_o` and `vco_khz_o` change only on a cycle where `done_o` is high.
- R10: `req_ready_o` is low from acceptance until the result cycle. A `req_valid_i` during that time does not change the result being computed.
- R11: A result with `err_o` high reports N, M and the VCO frequency as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| pix_khz_i | input | CLK_W | Pixel clock in kHz |
| lane_cnt_i | input | LANE_W | Number of lanes |
| fmt_i | input | 3 | Pixel-format code (see R1, R2) |
| ref_khz_i | input | CLK_W | PLL reference frequency in kHz |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | The last request had no valid solution |
| div_n_o | output | N_W | Chosen input divider |
| div_m_o | output | M_W | Chosen feedback divider |
| vco_khz_o | output | ACC_W | VCO frequency reached, in kHz |

## Verification
The assertions rely on three conditions. The reference frequency fits in CLK_W bits, so the largest N fits in N_W bits. Products such as target × N and M × fref stay below 2^ACC_W. The divider is never started with a zero denominator once the N loop is running.

The stimulus keeps to these conditions by using reference frequencies from 3 MHz to 100 MHz, lane counts from 0 to 4 and pixel clocks up to 300 MHz. It also covers the error paths: an unsupported format code, zero lanes, a target exactly at the rate limit, an empty N range, and a target too low for any even M of at least 6. A competing request is raised in the middle of a search to show that it is ignored.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int FMT_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LANE,
    ST_NMIN,
    ST_NMAX,
    ST_NCHK,
    ST_MDIV,
    ST_FDIV,
    ST_NEXT,
    ST_FIN
  } srch_st_e;

  // bits per pixel for each supported format code, 0 for unsupported codes
  function automatic logic [4:0] fmt_bpp(input logic [FMT_W-1:0] code);
    case (code)
      3'd0, 3'd1: fmt_bpp = 5'd24;
      3'd2:       fmt_bpp = 5'd18;
      3'd3:       fmt_bpp = 5'd16;
      default:    fmt_bpp = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/pll_divu.sv
module pll_divu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q, num_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    trial;
  logic          take;
  logic [W-1:0]  rem_nx;

  always_comb begin
    trial  = {rem_q, quo_q[W-1]};
    take   = trial >= {1'b0, den_q};
    rem_nx = take ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        num_q <= num_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q  <= rem_nx;
        quo_q  <= {quo_q[W-2:0], take};
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  logic [2*W-1:0] chk_back;
  assign chk_back = ({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q}) + {{W{1'b0}}, rem_q};

  // R1: every quotient handed out is the exact floor of num / den
  p_floor_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && den_q != '0) |-> (chk_back == {{W{1'b0}}, num_q} && rem_q < den_q));

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/pll_cand_screen.sv
module pll_cand_screen #(
  parameter int ACC_W       = 32,
  parameter int M_LO        = 6,
  parameter int M_HI        = 512,
  parameter int VCO_MIN_KHZ = 80000,
  parameter int VCO_MAX_KHZ = 1500000
) (
  input  logic [ACC_W-1:0] m_raw_i,
  input  logic [ACC_W-1:0] f_i,
  input  logic [ACC_W-1:0] tgt_i,
  input  logic [ACC_W-1:0] best_err_i,
  output logic [ACC_W-1:0] m_even_o,
  output logic             m_ok_o,
  output logic             f_ok_o,
  output logic [ACC_W-1:0] f_err_o,
  output logic             better_o
);
  localparam logic [ACC_W-1:0] M_LO_V  = ACC_W'(M_LO);
  localparam logic [ACC_W-1:0] M_HI_V  = ACC_W'(M_HI);
  localparam logic [ACC_W-1:0] F_LO_V  = ACC_W'(VCO_MIN_KHZ);
  localparam logic [ACC_W-1:0] F_HI_V  = ACC_W'(VCO_MAX_KHZ);

  always_comb begin
    m_even_o = m_raw_i + {{(ACC_W-1){1'b0}}, m_raw_i[0]};
    m_ok_o   = (m_even_o >= M_LO_V) && (m_even_o <= M_HI_V);
    f_ok_o   = (f_i >= F_LO_V) && (f_i <= F_HI_V);
    f_err_o  = (tgt_i >= f_i) ? (tgt_i - f_i) : (f_i - tgt_i);
    better_o = f_err_o < best_err_i;
  end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int CLK_W        = 20,
  parameter int LANE_W       = 3,
  parameter int N_W          = 8,
  parameter int M_W          = 10,
  parameter int ACC_W        = 32,
  parameter int RATE_MAX_KHZ = 1500000,
  parameter int VCO_MIN_KHZ  = 80000,
  parameter int PFD_MIN_KHZ  = 5000,
  parameter int PFD_MAX_KHZ  = 40000,
  parameter int M_LO         = 6,
  parameter int M_HI         = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CLK_W-1:0]  pix_khz_i,
  input  logic [LANE_W-1:0] lane_cnt_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [CLK_W-1:0]  ref_khz_i,
  output logic              done_o,
  output logic              err_o,
  output logic [N_W-1:0]    div_n_o,
  output logic [M_W-1:0]    div_m_o,
  output logic [ACC_W-1:0]  vco_khz_o
);
  localparam logic [ACC_W-1:0] RATE_LIM = ACC_W'(RATE_MAX_KHZ);
  localparam logic [ACC_W-1:0] PFD_LO   = ACC_W'(PFD_MIN_KHZ);
  localparam logic [ACC_W-1:0] PFD_HI   = ACC_W'(PFD_MAX_KHZ);
  localparam logic [ACC_W-1:0] VCO_LO   = ACC_W'(VCO_MIN_KHZ);
  localparam logic [ACC_W-1:0] M_LO_V   = ACC_W'(M_LO);
  localparam logic [ACC_W-1:0] M_HI_V   = ACC_W'(M_HI);

  srch_st_e            st_q;
  logic [CLK_W-1:0]    pix_q, ref_q;
  logic [4:0]          bpp_q;
  logic [ACC_W-1:0]    tgt_q;
  logic [N_W:0]        n_q, nmax_q;
  logic [M_W-1:0]      m_q;
  logic [N_W-1:0]      best_n_q;
  logic [M_W-1:0]      best_m_q;
  logic [ACC_W-1:0]    best_f_q, best_err_q;
  logic                found_q;

  logic                go_q;
  logic [ACC_W-1:0]    dnum_q, dden_q;
  logic                d_done;
  logic [ACC_W-1:0]    d_quot;

  logic [4:0]          bpp_in;
  logic [ACC_W-1:0]    tgt_nx;
  logic [ACC_W-1:0]    ref_w;
  logic [ACC_W-1:0]    m_even, f_err;
  logic                m_ok, f_ok, better;

  assign bpp_in = fmt_bpp(fmt_i);
  assign ref_w  = ACC_W'(ref_q);
  assign tgt_nx = ((d_quot * ACC_W'(bpp_q)) >> 3) * ACC_W'(10);

  pll_divu #(.W(ACC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (go_q),
    .num_i   (dnum_q),
    .den_i   (dden_q),
    .done_o  (d_done),
    .quot_o  (d_quot)
  );

  pll_cand_screen #(
    .ACC_W       (ACC_W),
    .M_LO        (M_LO),
    .M_HI        (M_HI),
    .VCO_MIN_KHZ (VCO_MIN_KHZ),
    .VCO_MAX_KHZ (RATE_MAX_KHZ)
  ) u_screen (
    .m_raw_i    (d_quot),
    .f_i        (d_quot),
    .tgt_i      (tgt_q),
    .best_err_i (best_err_q),
    .m_even_o   (m_even),
    .m_ok_o     (m_ok),
    .f_ok_o     (f_ok),
    .f_err_o    (f_err),
    .better_o   (better)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pix_q      <= '0;
      ref_q      <= '0;
      bpp_q      <= '0;
      tgt_q      <= '0;
      n_q        <= '0;
      nmax_q     <= '0;
      m_q        <= '0;
      best_n_q   <= '0;
      best_m_q   <= '0;
      best_f_q   <= '0;
      best_err_q <= '0;
      found_q    <= 1'b0;
      go_q       <= 1'b0;
      dnum_q     <= '0;
      dden_q     <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      div_n_o    <= '0;
      div_m_o    <= '0;
      vco_khz_o  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            pix_q      <= pix_khz_i;
            ref_q      <= ref_khz_i;
            bpp_q      <= bpp_in;
            found_q    <= 1'b0;
            best_err_q <= RATE_LIM;
            if (bpp_in == '0 || lane_cnt_i == '0) begin
              st_q <= ST_FIN;
            end else begin
              go_q   <= 1'b1;
              dnum_q <= ACC_W'(pix_khz_i);
              dden_q <= ACC_W'(lane_cnt_i);
              st_q   <= ST_LANE;
            end
          end
        end
        ST_LANE: begin
          if (d_done) begin
            tgt_q <= tgt_nx;
            if (tgt_nx >= RATE_LIM) begin
              st_q <= ST_FIN;
            end else begin
              go_q   <= 1'b1;
              dnum_q <= ref_w + PFD_HI - ACC_W'(1);
              dden_q <= PFD_HI;
              st_q   <= ST_NMIN;
            end
          end
        end
        ST_NMIN: begin
          if (d_done) begin
            n_q    <= (d_quot == '0) ? (N_W+1)'(1) : (N_W+1)'(d_quot);
            go_q   <= 1'b1;
            dnum_q <= ref_w;
            dden_q <= PFD_LO;
            st_q   <= ST_NMAX;
          end
        end
        ST_NMAX: begin
          if (d_done) begin
            nmax_q <= (N_W+1)'(d_quot);
            st_q   <= ST_NCHK;
          end
        end
        ST_NCHK: begin
          if (n_q > nmax_q) begin
            st_q <= ST_FIN;
          end else begin
            go_q   <= 1'b1;
            dnum_q <= tgt_q * ACC_W'(n_q);
            dden_q <= ref_w;
            st_q   <= ST_MDIV;
          end
        end
        ST_MDIV: begin
          if (d_done) begin
            if (m_ok) begin
              m_q    <= M_W'(m_even);
              go_q   <= 1'b1;
              dnum_q <= m_even * ref_w;
              dden_q <= ACC_W'(n_q);
              st_q   <= ST_FDIV;
            end else begin
              st_q <= ST_NEXT;
            end
          end
        end
        ST_FDIV: begin
          if (d_done) begin
            if (f_ok && better) begin
              best_n_q   <= N_W'(n_q);
              best_m_q   <= m_q;
              best_f_q   <= d_quot;
              best_err_q <= f_err;
              found_q    <= 1'b1;
            end
            st_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          n_q  <= n_q + 1'b1;
          st_q <= ST_NCHK;
        end
        ST_FIN: begin
          done_o    <= 1'b1;
          err_o     <= !found_q;
          div_n_o   <= found_q ? best_n_q : '0;
          div_m_o   <= found_q ? best_m_q : '0;
          vco_khz_o <= found_q ? best_f_q : '0;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);

  // R9: single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: results move only together with the strobe
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(err_o) && $stable(div_n_o) && $stable(div_m_o) && $stable(vco_khz_o)));

  // R10: latched request stays put while busy
  p_busy_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready_o |=> ($stable(pix_q) && $stable(ref_q) && $stable(bpp_q)));

  // R5: reported M is even and inside its window
  p_m_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (!div_m_o[0] && ACC_W'(div_m_o) >= M_LO_V && ACC_W'(div_m_o) <= M_HI_V));

  // R6: reported VCO inside its window
  p_vco_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (vco_khz_o >= VCO_LO && vco_khz_o <= RATE_LIM));

  // R4: reported N keeps the phase detector between its limits
  p_n_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (ACC_W'(div_n_o) * PFD_HI >= ref_w && ACC_W'(div_n_o) * PFD_LO <= ref_w));

  // R11: error results are zeroed
  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (div_n_o == '0 && div_m_o == '0 && vco_khz_o == '0));

  // R7: kept distance never grows during a search
  p_best_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FDIV || st_q == ST_NEXT || st_q == ST_NCHK || st_q == ST_MDIV) |=>
      (best_err_q <= $past(best_err_q)));

endmodule

// File: tb/test_pll_div_search.sv
module test_pll_div_search;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [19:0] pix_khz_i;
  logic [2:0]  lane_cnt_i;
  logic [2:0]  fmt_i;
  logic [19:0] ref_khz_i;
  logic        done_o, err_o;
  logic [7:0]  div_n_o;
  logic [9:0]  div_m_o;
  logic [31:0] vco_khz_o;

  always #5 clk = ~clk;

  pll_div_search i_pll_div_search (
    .clk (clk), .rst_n (rst_n),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .pix_khz_i (pix_khz_i), .lane_cnt_i (lane_cnt_i), .fmt_i (fmt_i), .ref_khz_i (ref_khz_i),
    .done_o (done_o), .err_o (err_o), .div_n_o (div_n_o), .div_m_o (div_m_o), .vco_khz_o (vco_khz_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit hold_bad = 1'b0;
  logic        p_err;
  logic [7:0]  p_n;
  logic [9:0]  p_m;
  logic [31:0] p_v;

  // per-clock comparison: outputs may move only on the strobe (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!done_o && (err_o !== p_err || div_n_o !== p_n || div_m_o !== p_m || vco_khz_o !== p_v))
        hold_bad = 1'b1;
    end
    p_err = err_o; p_n = div_n_o; p_m = div_m_o; p_v = vco_khz_o;
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural model of the search
  bit     x_err;
  longint x_n, x_m, x_f;
  task automatic model(input longint pix, input longint lanes, input longint code, input longint fref);
    longint bpp, tgt, lo, hi, best, mm, ff, d;
    bit found;
    x_err = 1'b1; x_n = 0; x_m = 0; x_f = 0;
    case (code)
      0, 1: bpp = 24;
      2: bpp = 18;
      3: bpp = 16;
      default: bpp = 0;
    endcase
    if (bpp == 0 || lanes == 0) return;
    tgt = ((pix / lanes) * bpp / 8) * 10;
    if (tgt >= 1500000) return;
    lo = (fref + 39999) / 40000;
    if (lo < 1) lo = 1;
    hi = fref / 5000;
    best = 1500000;
    found = 1'b0;
    for (longint nn = lo; nn <= hi; nn++) begin
      mm = tgt * nn / fref;
      mm = mm + (mm % 2);
      if (mm < 6 || mm > 512) continue;
      ff = mm * fref / nn;
      if (ff < 80000 || ff > 1500000) continue;
      d = (tgt > ff) ? tgt - ff : ff - tgt;
      if (d < best) begin
        best = d; found = 1'b1; x_n = nn; x_m = mm; x_f = ff;
      end
    end
    x_err = !found;
  endtask

  task automatic run_case(input string tag, input int pix, input int lanes, input int code,
                          input int fref, input bit intrude, input bit quick);
    int lat;
    bit got;
    model(pix, lanes, code, fref);
    hold_bad = 1'b0;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    pix_khz_i = 20'(pix); lane_cnt_i = 3'(lanes); fmt_i = 3'(code); ref_khz_i = 20'(fref);
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 0;
    got = 1'b0;
    if (intrude) begin
      bit busy_ok = 1'b1;
      repeat (2) @(negedge clk);
      pix_khz_i = 20'd200000; lane_cnt_i = 3'd1; fmt_i = 3'd3; ref_khz_i = 20'd50000;
      req_valid_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (req_ready_o) busy_ok = 1'b0;
      end
      req_valid_i = 1'b0;
      lat = 7;
      check("R10", "ready while busy", busy_ok ? 0 : 1, 0);
    end
    while (!got && lat < 30000) begin
      @(negedge clk);
      lat++;
      if (done_o) got = 1'b1;
    end
    if (!got) begin
      n_run++; n_fail++;
      $display("FAIL %s watchdog: actual no done expected done", tag);
      return;
    end
    check(tag, "err", err_o, x_err);
    check(tag, "N", div_n_o, x_n);
    check(tag, "M", div_m_o, x_m);
    check(tag, "vco", vco_khz_o, x_f);
    if (x_err) check("R11", "zeroed", div_n_o + div_m_o + vco_khz_o, 0);
    if (quick) check("R2", "latency", lat <= 2 ? 1 : 0, 1);
    @(negedge clk);
    check("R9", "pulse width", done_o, 0);
    check("R9", "hold between strobes", hold_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid_i = 1'b0;
    pix_khz_i = '0; lane_cnt_i = '0; fmt_i = '0; ref_khz_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "reset ready", req_ready_o, 1);
    check("R9", "reset done", done_o, 0);
    check("R11", "reset err", err_o, 0);
    check("R11", "reset N", div_n_o, 0);

    run_case("R1", 148500, 4, 0, 24000, 1'b0, 1'b0);
    run_case("R1", 70000, 2, 3, 24000, 1'b0, 1'b0);
    run_case("R5", 65000, 1, 2, 27000, 1'b0, 1'b0);
    run_case("R4", 300000, 4, 1, 50000, 1'b0, 1'b0);
    run_case("R6", 25000, 1, 3, 100000, 1'b0, 1'b0);
    run_case("R7", 74999, 1, 3, 100000, 1'b0, 1'b0);
    run_case("R2", 100000, 2, 5, 24000, 1'b0, 1'b1);
    run_case("R2", 100000, 0, 0, 24000, 1'b0, 1'b1);
    run_case("R3", 75000, 1, 3, 24000, 1'b0, 1'b0);
    run_case("R3", 300000, 1, 0, 24000, 1'b0, 1'b0);
    run_case("R8", 100000, 2, 0, 3000, 1'b0, 1'b0);
    run_case("R8", 1000, 4, 3, 24000, 1'b0, 1'b0);
    run_case("R10", 148500, 4, 0, 24000, 1'b1, 1'b0);
    run_case("R1", 162000, 3, 2, 26000, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule